// File: doc/BRIEF.md
# Instruction Cache Set Parity Scrubber

This block walks every way of one set of a four-way instruction cache and looks for parity damage. A start pulse supplies a set index and a flag that selects a tag-only or a tag-plus-data sweep. For each way the block issues one tag read through a synchronous read port. The port answers on the next cycle. The block then checks two address-tag parity groups and a duplicated copy of the valid bit.

When the data flag is set, each way also gets four data reads. Each data beat carries a predecode byte protected by one parity bit, plus two packed 32-bit instructions. Each instruction has a 4-bit byte-parity nibble.

At the end of the sweep the block raises a one-cycle done pulse. It reports sticky tag-error and data-error flags and the number of the first way that showed a fault. The flags hold until the next accepted start. The cache array is outside the block.

Top module: `icache_set_scrub`

## Requirements
- R1: Ways are visited in the order 0, 1, 2, 3. Each tag read uses address (way << 13) | index, with rd_kind_o = 0.
- R2: When tag-high bit 29 (valid) is 1, tag-low bit 10 must equal the XOR of tag-low bits 23..0 excluding bits 10 and 11. A mismatch sets tag_err_o.
- R3: When the valid bit is 1, tag-low bit 11 must equal the XOR of tag-low bits 63..24. A mismatch sets tag_err_o. Neither group is checked for an invalid way.
- R4: For every way, whether valid or not, tag-high bit 29 must equal tag-high bit 27. A mismatch sets tag_err_o.
- R5: With the data flag set, each way's tag read is followed by four data reads (rd_kind_o = 1) at offsets 0..3, placed at address bits 4:3. With the flag clear, no data read is issued and no data fault is reported.
- R6: In each data beat, data-high bit 16 must equal the XOR of data-high bits 15..8. A mismatch sets data_err_o.
- R7: Instruction A is checked against data-high bits 7..4 and instruction B against bits 3..0. Each nibble bit is the XOR of one byte, with the top byte (31..24) in the nibble's top bit. A mismatch sets data_err_o.
- R8: Every read request lasts one cycle and is checked in the following cycle. busy_o is high from the cycle after start until done_o. done_o is a single-cycle pulse that arrives 4×2+1 cycles after start for a tag-only sweep and 4×10+1 cycles for a tag-plus-data sweep.
- R9: A start while busy has no effect on the running sweep.
- R10: tag_err_o and data_err_o are sticky through a sweep and are cleared by an accepted start.
- R11: fail_way_o holds the way of the first fault of the sweep, and is 0 when there is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a sweep (accepted only when idle) |
| set_idx_i | input | 13 | Set index; bits 4:3 expected zero |
| data_en_i | input | 1 | Also check data beats |
| rd_req_o | output | 1 | Read request to the cache array |
| rd_kind_o | output | 1 | 0 = tag read, 1 = data read |
| rd_addr_o | output | 15 | Read address: way at 14:13, index, beat offset at 4:3 |
| rd_tag_hi_i | input | 32 | Tag high word, valid the cycle after request |
| rd_tag_lo_i | input | 64 | Tag low word |
| rd_dat_hi_i | input | 32 | Data parity word |
| rd_ins_a_i | input | 32 | Instruction A |
| rd_ins_b_i | input | 32 | Instruction B |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle completion pulse |
| tag_err_o | output | 1 | Sticky tag parity fault |
| data_err_o | output | 1 | Sticky data parity fault |
| fail_way_o | output | 2 | Way of first fault |

## Verification
Clean sweeps, in both tag-only and tag-plus-data mode, establish the access order and the cycle count of each mode. Single faults in each tag group, in the duplicated valid bit, in the predecode bit and in each instruction nibble show that every check is wired to its own field. Faulty group bits on an invalid way, and data faults during a tag-only sweep, show that these cases are masked. A start injected mid-sweep, and a clean sweep following a faulty one, separate a wrongly accepted restart from correct clearing. Using two faults in different ways separates first-fault capture from last-fault capture.

// File: rtl/icsc_pkg.sv
package icsc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAG_RD,
        ST_TAG_CHK,
        ST_DATA_RD,
        ST_DATA_CHK,
        ST_DONE
    } icsc_state_e;
endpackage

// File: rtl/icsc_tag_check.sv
module icsc_tag_check #(
    parameter int TAG_HI_W   = 32,
    parameter int TAG_LO_W   = 64,
    parameter int VALID_BIT  = 29,
    parameter int VCOPY_BIT  = 27,
    parameter int PAR_LO_BIT = 10,
    parameter int PAR_HI_BIT = 11,
    parameter int SPLIT      = 24
) (
    input  logic [TAG_HI_W-1:0] tag_hi,
    input  logic [TAG_LO_W-1:0] tag_lo,
    output logic                err_low_grp,
    output logic                err_high_grp,
    output logic                err_valid
);
    logic valid;
    logic low_par;
    logic high_par;

    assign valid = tag_hi[VALID_BIT];

    always_comb begin
        low_par = 1'b0;
        for (int i = 0; i < SPLIT; i++) begin
            if (i != PAR_LO_BIT && i != PAR_HI_BIT) begin
                low_par = low_par ^ tag_lo[i];
            end
        end
    end

    assign high_par     = ^tag_lo[TAG_LO_W-1:SPLIT];
    assign err_low_grp  = valid && (tag_lo[PAR_LO_BIT] != low_par);
    assign err_high_grp = valid && (tag_lo[PAR_HI_BIT] != high_par);
    assign err_valid    = tag_hi[VALID_BIT] != tag_hi[VCOPY_BIT];
endmodule

// File: rtl/icsc_data_check.sv
module icsc_data_check #(
    parameter int DHI_W     = 32,
    parameter int INST_W    = 32,
    parameter int PD_LSB    = 8,
    parameter int PD_PARBIT = 16
) (
    input  logic [DHI_W-1:0]  dat_hi,
    input  logic [INST_W-1:0] ins_a,
    input  logic [INST_W-1:0] ins_b,
    output logic              err_predecode,
    output logic [1:0]        err_inst
);
    localparam int NBYTES = INST_W / 8;

    logic [INST_W-1:0] ins [2];
    assign ins[0] = ins_a;
    assign ins[1] = ins_b;

    assign err_predecode = dat_hi[PD_PARBIT] != (^dat_hi[PD_LSB+7:PD_LSB]);

    for (genvar g = 0; g < 2; g++) begin : g_inst
        localparam int FLD_LSB = (1 - g) * NBYTES;
        logic [NBYTES-1:0] code;
        always_comb begin
            for (int b = 0; b < NBYTES; b++) begin
                code[b] = ^ins[g][b*8 +: 8];
            end
        end
        assign err_inst[g] = code != dat_hi[FLD_LSB +: NBYTES];
    end
endmodule

// File: rtl/icache_set_scrub.sv
module icache_set_scrub
    import icsc_pkg::*;
#(
    parameter int IDX_W     = 13,
    parameter int NUM_WAYS  = 4,
    parameter int NUM_BEATS = 4,
    parameter int BEAT_LSB  = 3,
    parameter int TAG_HI_W  = 32,
    parameter int TAG_LO_W  = 64,
    parameter int DHI_W     = 32,
    parameter int INST_W    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [IDX_W-1:0]         set_idx_i,
    input  logic                     data_en_i,
    output logic                     rd_req_o,
    output logic                     rd_kind_o,
    output logic [IDX_W+$clog2(NUM_WAYS)-1:0] rd_addr_o,
    input  logic [TAG_HI_W-1:0]      rd_tag_hi_i,
    input  logic [TAG_LO_W-1:0]      rd_tag_lo_i,
    input  logic [DHI_W-1:0]         rd_dat_hi_i,
    input  logic [INST_W-1:0]        rd_ins_a_i,
    input  logic [INST_W-1:0]        rd_ins_b_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     tag_err_o,
    output logic                     data_err_o,
    output logic [$clog2(NUM_WAYS)-1:0] fail_way_o
);
    localparam int WAY_W  = $clog2(NUM_WAYS);
    localparam int BEAT_W = $clog2(NUM_BEATS);
    localparam int ADDR_W = IDX_W + WAY_W;
    localparam logic [IDX_W-1:0] OFF_MASK = IDX_W'(((1 << BEAT_W) - 1) << BEAT_LSB);

    typedef struct packed {
        icsc_state_e        state;
        logic [WAY_W-1:0]   way;
        logic [BEAT_W-1:0]  beat;
        logic [IDX_W-1:0]   idx;
        logic               den;
        logic               tag_err;
        logic               data_err;
        logic               seen;
        logic [WAY_W-1:0]   fail_way;
    } regs_t;

    regs_t r_d, r_q;

    logic t_lo, t_hi, t_vld, d_pd;
    logic [1:0] d_ins;
    logic tag_fault, data_fault;

    icsc_tag_check #(
        .TAG_HI_W(TAG_HI_W),
        .TAG_LO_W(TAG_LO_W)
    ) i_tag (
        .tag_hi      (rd_tag_hi_i),
        .tag_lo      (rd_tag_lo_i),
        .err_low_grp (t_lo),
        .err_high_grp(t_hi),
        .err_valid   (t_vld)
    );

    icsc_data_check #(
        .DHI_W (DHI_W),
        .INST_W(INST_W)
    ) i_dat (
        .dat_hi       (rd_dat_hi_i),
        .ins_a        (rd_ins_a_i),
        .ins_b        (rd_ins_b_i),
        .err_predecode(d_pd),
        .err_inst     (d_ins)
    );

    assign tag_fault  = t_lo | t_hi | t_vld;
    assign data_fault = d_pd | (|d_ins);

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state    = ST_TAG_RD;
                    r_d.way      = '0;
                    r_d.beat     = '0;
                    r_d.idx      = set_idx_i;
                    r_d.den      = data_en_i;
                    r_d.tag_err  = 1'b0;
                    r_d.data_err = 1'b0;
                    r_d.seen     = 1'b0;
                    r_d.fail_way = '0;
                end
            end
            ST_TAG_RD:  r_d.state = ST_TAG_CHK;
            ST_TAG_CHK: begin
                if (tag_fault) begin
                    r_d.tag_err = 1'b1;
                    if (!r_q.seen) begin
                        r_d.seen     = 1'b1;
                        r_d.fail_way = r_q.way;
                    end
                end
                if (r_q.den) begin
                    r_d.beat  = '0;
                    r_d.state = ST_DATA_RD;
                end else if (r_q.way == WAY_W'(NUM_WAYS - 1)) begin
                    r_d.state = ST_DONE;
                end else begin
                    r_d.way   = r_q.way + 1'b1;
                    r_d.state = ST_TAG_RD;
                end
            end
            ST_DATA_RD: r_d.state = ST_DATA_CHK;
            ST_DATA_CHK: begin
                if (data_fault) begin
                    r_d.data_err = 1'b1;
                    if (!r_q.seen) begin
                        r_d.seen     = 1'b1;
                        r_d.fail_way = r_q.way;
                    end
                end
                if (r_q.beat != BEAT_W'(NUM_BEATS - 1)) begin
                    r_d.beat  = r_q.beat + 1'b1;
                    r_d.state = ST_DATA_RD;
                end else if (r_q.way == WAY_W'(NUM_WAYS - 1)) begin
                    r_d.state = ST_DONE;
                end else begin
                    r_d.way   = r_q.way + 1'b1;
                    r_d.state = ST_TAG_RD;
                end
            end
            ST_DONE: r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_addr_o = {r_q.way, r_q.idx};
        if (r_q.state == ST_DATA_RD) begin
            rd_addr_o[BEAT_LSB +: BEAT_W] = r_q.beat;
        end
    end

    assign rd_req_o   = (r_q.state == ST_TAG_RD) || (r_q.state == ST_DATA_RD);
    assign rd_kind_o  = (r_q.state == ST_DATA_RD);
    assign busy_o     = (r_q.state != ST_IDLE) && (r_q.state != ST_DONE);
    assign done_o     = (r_q.state == ST_DONE);
    assign tag_err_o  = r_q.tag_err;
    assign data_err_o = r_q.data_err;
    assign fail_way_o = r_q.fail_way;

    assert_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> ((rd_addr_o[IDX_W-1:0] | OFF_MASK) == (r_q.idx | OFF_MASK)));
    assert_no_data_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_kind_o) |-> r_q.den);
    assert_single_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |=> !rd_req_o);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !done_o) |=> (!tag_err_o && !data_err_o));
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && tag_err_o) |=> tag_err_o);
    assert_first_way_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && (tag_err_o || data_err_o)) |=> $stable(fail_way_o));
endmodule

// File: tb/test_icache_set_scrub.sv
`timescale 1ns/1ps
module test_icache_set_scrub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [12:0] set_idx_i = '0;
    logic        data_en_i = 1'b0;
    logic        rd_req_o, rd_kind_o;
    logic [14:0] rd_addr_o;
    logic [31:0] m_thi, m_dhi, m_ia, m_ib;
    logic [63:0] m_tlo;
    logic        busy_o, done_o, tag_err_o, data_err_o;
    logic [1:0]  fail_way_o;

    logic [31:0] thi [4];
    logic [63:0] tlo [4];
    logic [31:0] dhi [4][4];
    logic [31:0] ia  [4][4];
    logic [31:0] ib  [4][4];

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    icache_set_scrub i_icache_set_scrub (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .set_idx_i(set_idx_i),
        .data_en_i(data_en_i), .rd_req_o(rd_req_o), .rd_kind_o(rd_kind_o),
        .rd_addr_o(rd_addr_o), .rd_tag_hi_i(m_thi), .rd_tag_lo_i(m_tlo),
        .rd_dat_hi_i(m_dhi), .rd_ins_a_i(m_ia), .rd_ins_b_i(m_ib),
        .busy_o(busy_o), .done_o(done_o), .tag_err_o(tag_err_o),
        .data_err_o(data_err_o), .fail_way_o(fail_way_o)
    );

    // array model with one-cycle read latency
    always @(posedge clk) begin
        if (rd_req_o) begin
            m_thi <= thi[rd_addr_o[14:13]];
            m_tlo <= tlo[rd_addr_o[14:13]];
            m_dhi <= dhi[rd_addr_o[14:13]][rd_addr_o[4:3]];
            m_ia  <= ia[rd_addr_o[14:13]][rd_addr_o[4:3]];
            m_ib  <= ib[rd_addr_o[14:13]][rd_addr_o[4:3]];
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit par(input logic [63:0] v);
        return bit'($countones(v) % 2);
    endfunction

    function automatic logic [3:0] nib(input logic [31:0] w);
        logic [3:0] n;
        for (int k = 0; k < 4; k++) n[3-k] = par({56'd0, w[31-8*k -: 8]});
        return n;
    endfunction

    task automatic make_tag(input int w, input bit vld, input logic [63:0] seed);
        logic [63:0] lo;
        lo = seed;
        lo[10] = par({40'd0, lo[23:12], 2'b00, lo[9:0]});
        lo[11] = par({24'd0, lo[63:24]});
        tlo[w] = lo;
        thi[w] = 32'h0012_3400;
        thi[w][29] = vld;
        thi[w][27] = vld;
    endtask

    task automatic init_good();
        for (int w = 0; w < 4; w++) begin
            make_tag(w, 1'b1, 64'hC3A5_1F00_9B7E_4D21 ^ (64'(w) * 64'h0101_0000_1357_9BDF));
            for (int b = 0; b < 4; b++) begin
                ia[w][b] = 32'h0100_0000 | 32'(w * 37 + b * 5);
                ib[w][b] = 32'h0300_0080 ^ 32'(w * 11 + b * 64);
                dhi[w][b] = '0;
                dhi[w][b][15:8] = 8'(8'h5B + w * 3 + b);
                dhi[w][b][16] = par({56'd0, dhi[w][b][15:8]});
                dhi[w][b][7:4] = nib(ia[w][b]);
                dhi[w][b][3:0] = nib(ib[w][b]);
            end
        end
    endtask

    // reference model: expected access list, flags, first way, done cycle
    task automatic run(input logic [12:0] idx, input bit den, input int poke, input string tg);
        int unsigned q[$];
        bit e_tag, e_dat, seen;
        int e_way, e_done, cyc;
        bit tf, df;
        e_tag = 0; e_dat = 0; seen = 0; e_way = 0;
        for (int w = 0; w < 4; w++) begin
            q.push_back({1'b0, 2'(w), idx});
            tf = (thi[w][29] != thi[w][27]);
            if (thi[w][29]) begin
                tf |= tlo[w][10] != par({40'd0, tlo[w][23:12], 2'b00, tlo[w][9:0]});
                tf |= tlo[w][11] != par({24'd0, tlo[w][63:24]});
            end
            df = 0;
            if (den) begin
                for (int b = 0; b < 4; b++) begin
                    q.push_back({1'b1, 2'(w), idx | 13'(b << 3)});
                    df |= dhi[w][b][16] != par({56'd0, dhi[w][b][15:8]});
                    df |= dhi[w][b][7:4] != nib(ia[w][b]);
                    df |= dhi[w][b][3:0] != nib(ib[w][b]);
                end
            end
            if ((tf || df) && !seen) begin seen = 1; e_way = w; end
            e_tag |= tf; e_dat |= df;
        end
        e_done = 4 * (den ? 10 : 2) + 1;
        @(negedge clk);
        start_i = 1'b1; set_idx_i = idx; data_en_i = den;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 1;
        while (1) begin
            if (rd_req_o) begin
                int unsigned exp_a;
                exp_a = (q.size() > 0) ? q.pop_front() : 32'hFFFF;
                chk({rd_kind_o, rd_addr_o} == exp_a[15:0], "R1/R5",
                    {tg, " read order"}, {rd_kind_o, rd_addr_o}, exp_a);
            end
            chk(busy_o == (cyc < e_done), "R8", {tg, " busy"}, busy_o, cyc < e_done);
            if (cyc == poke) begin
                start_i = 1'b1; set_idx_i = idx ^ 13'h1F00; data_en_i = !den;
            end else begin
                start_i = 1'b0; set_idx_i = idx; data_en_i = den;
            end
            if (done_o || cyc > 100) break;
            @(negedge clk);
            cyc++;
        end
        start_i = 1'b0;
        chk(cyc == e_done, "R8", {tg, " done cycle"}, cyc, e_done);
        chk(q.size() == 0, "R5", {tg, " reads missing"}, q.size(), 0);
        chk(tag_err_o == e_tag, "R2/R3/R4", {tg, " tag flag"}, tag_err_o, e_tag);
        chk(data_err_o == e_dat, "R6/R7", {tg, " data flag"}, data_err_o, e_dat);
        chk(fail_way_o == 2'(e_way), "R11", {tg, " first way"}, fail_way_o, e_way);
        @(negedge clk);
        chk(!done_o, "R8", {tg, " done single pulse"}, done_o, 0);
        chk(tag_err_o == e_tag && data_err_o == e_dat, "R10",
            {tg, " flags held"}, {tag_err_o, data_err_o}, {e_tag, e_dat});
    endtask

    initial begin
        init_good();
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !rd_req_o, "R8", "reset outputs", {busy_o, done_o, rd_req_o}, 0);
        chk(!tag_err_o && !data_err_o && fail_way_o == 0, "R10", "reset flags",
            {tag_err_o, data_err_o, fail_way_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R5 R7: clean sweeps in both modes
        run(13'h0AE0, 1'b1, 0, "R7 clean data");
        run(13'h1FE0, 1'b0, 0, "R5 clean tag");
        // R2 group A fault in way 2
        init_good(); tlo[2][5] ^= 1'b1;
        run(13'h0020, 1'b0, 0, "R2 grpA");
        // R3 group B in way 1 and group A in way 3: first way is 1 (R11)
        init_good(); tlo[1][40] ^= 1'b1; tlo[3][10] ^= 1'b1;
        run(13'h0100, 1'b0, 0, "R3 R11 grpB");
        // R2 R3 invalid way with broken groups is not checked
        init_good(); thi[0][29] = 0; thi[0][27] = 0; tlo[0][11] ^= 1'b1; tlo[0][10] ^= 1'b1;
        run(13'h0040, 1'b0, 0, "R3 invalid masked");
        // R4 valid copy mismatch on invalid way 3
        init_good(); thi[3][29] = 0; thi[3][27] = 1;
        run(13'h0040, 1'b0, 0, "R4 vcopy");
        // R6 predecode fault way 2 beat 3
        init_good(); dhi[2][3][16] ^= 1'b1;
        run(13'h0AE0, 1'b1, 0, "R6 predecode");
        // R7 instruction A fault way 0 beat 1 (top byte) and B fault way 3
        init_good(); ia[0][1][31] ^= 1'b1; dhi[3][2][0] ^= 1'b1;
        run(13'h0160, 1'b1, 0, "R7 R11 inst");
        // R7 only instruction B, bottom byte
        init_good(); ib[1][0][2] ^= 1'b1;
        run(13'h0160, 1'b1, 0, "R7 instB");
        // R5 data fault ignored in tag-only sweep
        init_good(); dhi[1][2][16] ^= 1'b1;
        run(13'h0160, 1'b0, 0, "R5 data off");
        // R9 mid-sweep start ignored; way 0 fault must survive
        init_good(); thi[0][27] ^= 1'b1;
        run(13'h0A00, 1'b1, 7, "R9 busy start");
        // R10 clean sweep after faulty one clears flags
        init_good();
        run(13'h0A00, 1'b1, 0, "R10 clear");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule